// File: doc/BRIEF.md
# Trace FIFO Client

A byte-wide character FIFO that sits between a 32-bit register interface and a serial trace transport. The same design serves either direction, and a parameter picks which one. In transmit mode, software writes characters into the data register and the FIFO drains them towards the transport over a valid/ready byte stream. In receive mode, the transport delivers bytes that have no back-pressure, and software pops them by reading the data register. The character format is fixed at eight data bits with no parity and one stop bit. No flow control is carried.

The block keeps five condition flags: empty, full, threshold request, sticky overflow and receive idle timeout. It exposes a live occupancy count. It also has a programmable request threshold, a programmable idle limit, and separate reset and flush commands. An interrupt unit latches the conditions into pending bits. Pending bits can be forced through a set register, removed through a write-one-to-clear register, and gated by a mask onto a single interrupt line.

Top module: `trace_fifo_client`

## Requirements
- R1: After reset the enable bit, threshold, mask and occupancy read 0. The status register shows empty=1, full=0, overflow=0 and timeout=0, and irq is low.
- R2: The byte offsets are fixed: enable 0x000 (bit 0), idle limit 0x004, threshold 0x008, command 0x00C, data 0x020, condition status 0x100, occupancy 0x104, pending 0x108, set 0x10C, mask 0x110 and clear 0x114. Status, pending, set, mask and clear all use the same bit order: bit 0 empty, bit 1 full, bit 2 request, bit 3 overflow, bit 4 timeout. A written register reads back its value.
- R3: In transmit mode, writing the data register pushes bits 7:0. While enabled, link_out_valid is high whenever the FIFO is non-empty. Bytes leave on link_out_data in write order, one per cycle in which valid and ready are both high.
- R4: In receive mode, a cycle with link_in_valid high pushes link_in_data. A data-register read returns the oldest byte and pops it in that cycle. A read while the FIFO is empty returns 0 and changes nothing.
- R5: The occupancy register returns the live entry count, from 0 to DEPTH (128 by default). The full flag is set exactly at DEPTH and the empty flag exactly at 0.
- R6: A push while the FIFO is full is dropped and sets the overflow flag. The flag stays set until a clear-register write with bit 3 or a reset command.
- R7: While the enable bit is 0, pushes from both software and the transport are ignored, and occupancy does not change.
- R8: The request flag is set when occupancy is at or below the threshold in transmit mode, and at or above it in receive mode.
- R9: In receive mode, the timeout flag is set when the FIFO is non-empty and no byte has arrived for at least the idle-limit number of cycles. The flag drops when a byte arrives or the FIFO empties.
- R10: In the command register, bit 0 (reset) empties the FIFO and clears overflow. Bit 1 (flush) empties the FIFO and leaves overflow set. Both bits may be written together.
- R11: A pending bit is set in every cycle its condition holds, and also by a set-register write of 1. A clear-register write of 1 removes it only if its condition is no longer true. irq is the OR of pending AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| link_in_valid | input | 1 | Receive byte present (receive mode) |
| link_in_data | input | 8 | Receive byte |
| link_out_valid | output | 1 | Transmit byte present (transmit mode) |
| link_out_ready | input | 1 | Transport accepts the byte |
| link_out_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker checks the following on every cycle:
- occupancy stays within range, and full and empty never both hold;
- overflow stays set unless a clear or a reset is applied, and every dropped push sets it;
- a disabled block never gains entries;
- the interrupt line stays low under a zero mask;
- the transmit stream never offers data from an empty FIFO.

Only the bench scenarios can show:
- byte order through both directions;
- the exact occupancy at which each threshold comparison switches;
- the idle window of the timeout;
- the difference between flush and reset;
- that a clear cannot remove a pending bit whose condition is still true.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NFLAG = 5;

  localparam logic [11:0] OFS_ENABLE = 12'h000;
  localparam logic [11:0] OFS_IDLE   = 12'h004;
  localparam logic [11:0] OFS_THRESH = 12'h008;
  localparam logic [11:0] OFS_CMD    = 12'h00C;
  localparam logic [11:0] OFS_DATA   = 12'h020;
  localparam logic [11:0] OFS_STAT   = 12'h100;
  localparam logic [11:0] OFS_OCC    = 12'h104;
  localparam logic [11:0] OFS_PEND   = 12'h108;
  localparam logic [11:0] OFS_SET    = 12'h10C;
  localparam logic [11:0] OFS_MASK   = 12'h110;
  localparam logic [11:0] OFS_CLR    = 12'h114;

  localparam int unsigned CMD_RESET_BIT = 0;
  localparam int unsigned CMD_FLUSH_BIT = 1;
  localparam int unsigned FLAG_OVF_BIT  = 3;

  // packed so that bit 0 is empty and bit 4 is timeout
  typedef struct packed {
    logic tmo;
    logic ovf;
    logic req;
    logic full;
    logic empty;
  } tfc_flags_t;
endpackage

// File: rtl/tfc_fifo.sv
module tfc_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic push_ok, pop_ok;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLCNT = CNT_W'(DEPTH);

  assign full    = (cnt_q == FULLCNT);
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; written only on an accepted push
  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/tfc_idle.sv
module tfc_idle #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arrive,
  input  logic          empty,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || arrive || empty) cnt_d = '0;
    else if (cnt_q < limit)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = ~empty & (cnt_q >= limit);
endmodule

// File: rtl/tfc_irq.sv
module tfc_irq #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] pend_q, pend_d, mask_q, mask_d;
  logic [N-1:0] set_v, clr_v;

  assign set_v = set_we ? wbits : '0;
  assign clr_v = clr_we ? wbits : '0;

  always_comb begin
    pend_d = (pend_q & ~clr_v) | cond | set_v;
    mask_d = mask_we ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = |(pend_q & mask_q);
endmodule

// File: rtl/trace_fifo_client.sv
module trace_fifo_client
  import tfc_pkg::*;
#(
  parameter bit          IS_RX      = 1'b0,
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned IDLE_W     = 16,
  parameter int unsigned IDLE_RESET = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              link_in_valid,
  input  logic [7:0]        link_in_data,
  output logic              link_out_valid,
  input  logic              link_out_ready,
  output logic [7:0]        link_out_data,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic en_q, en_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic [IDLE_W-1:0] lim_q, lim_d;
  logic ovf_q, ovf_d;

  logic wr_en, wr_thr, wr_lim, wr_cmd, wr_data, rd_data;
  logic wr_set, wr_clr, wr_mask;
  logic cmd_reset, cmd_flush, fifo_clr, ovf_clr;

  logic push_req, push_try, push_ok, pop_req, pop_ok, drop;
  logic [7:0] push_byte, head;
  logic [CNT_W-1:0] count;
  logic full, empty, req, tmo_raw, tmo;
  tfc_flags_t flags;
  logic [NFLAG-1:0] pend, mask;
  logic unused_wdata;

  // register decode
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_en   = bus_sel & bus_wr & hit(bus_addr, OFS_ENABLE);
  assign wr_lim  = bus_sel & bus_wr & hit(bus_addr, OFS_IDLE);
  assign wr_thr  = bus_sel & bus_wr & hit(bus_addr, OFS_THRESH);
  assign wr_cmd  = bus_sel & bus_wr & hit(bus_addr, OFS_CMD);
  assign wr_data = bus_sel & bus_wr & hit(bus_addr, OFS_DATA);
  assign rd_data = bus_sel & ~bus_wr & hit(bus_addr, OFS_DATA);
  assign wr_set  = bus_sel & bus_wr & hit(bus_addr, OFS_SET);
  assign wr_clr  = bus_sel & bus_wr & hit(bus_addr, OFS_CLR);
  assign wr_mask = bus_sel & bus_wr & hit(bus_addr, OFS_MASK);

  assign cmd_reset = wr_cmd & bus_wdata[CMD_RESET_BIT];
  assign cmd_flush = wr_cmd & bus_wdata[CMD_FLUSH_BIT];
  assign fifo_clr  = cmd_reset | cmd_flush;
  assign ovf_clr   = cmd_reset | (wr_clr & bus_wdata[FLAG_OVF_BIT]);
  assign unused_wdata = ^bus_wdata[31:IDLE_W];

  // direction-specific wiring
  generate
    if (IS_RX) begin : g_rx
      logic unused_ready;
      assign unused_ready   = link_out_ready;
      assign push_req       = link_in_valid;
      assign push_byte      = link_in_data;
      assign pop_req        = rd_data;
      assign link_out_valid = 1'b0;
      assign link_out_data  = '0;
      assign req            = (count >= thr_q);
      assign tmo            = tmo_raw;
    end else begin : g_tx
      logic unused_link;
      assign unused_link    = ^{link_in_valid, link_in_data, rd_data, tmo_raw};
      assign push_req       = wr_data;
      assign push_byte      = bus_wdata[7:0];
      assign link_out_valid = en_q & ~empty;
      assign link_out_data  = head;
      assign pop_req        = link_out_valid & link_out_ready;
      assign req            = (count <= thr_q);
      assign tmo            = 1'b0;
    end
  endgenerate

  assign push_try = en_q & push_req & ~fifo_clr;
  assign push_ok  = push_try & ~full;
  assign drop     = push_try & full;
  assign pop_ok   = pop_req & ~empty & ~fifo_clr;

  tfc_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(push_try), .push_data(push_byte), .pop(pop_ok),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  tfc_idle #(.CW(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .arrive(push_ok),
    .empty(empty), .limit(lim_q), .expired(tmo_raw)
  );

  always_comb begin
    flags.empty = empty;
    flags.full  = full;
    flags.req   = req;
    flags.ovf   = ovf_q;
    flags.tmo   = tmo;
  end

  tfc_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .cond(flags),
    .set_we(wr_set), .clr_we(wr_clr), .mask_we(wr_mask),
    .wbits(bus_wdata[NFLAG-1:0]), .pend(pend), .mask(mask), .irq(irq)
  );

  // configuration and sticky overflow, next state
  always_comb begin
    en_d  = wr_en  ? bus_wdata[0] : en_q;
    thr_d = wr_thr ? bus_wdata[CNT_W-1:0] : thr_q;
    lim_d = wr_lim ? bus_wdata[IDLE_W-1:0] : lim_q;
    ovf_d = (ovf_q & ~ovf_clr) | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      lim_q <= IDLE_W'(IDLE_RESET);
      ovf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
      lim_q <= lim_d;
      ovf_q <= ovf_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_ENABLE))      bus_rdata[0] = en_q;
    else if (hit(bus_addr, OFS_IDLE))   bus_rdata[IDLE_W-1:0] = lim_q;
    else if (hit(bus_addr, OFS_THRESH)) bus_rdata[CNT_W-1:0] = thr_q;
    else if (hit(bus_addr, OFS_DATA))   bus_rdata[7:0] = (IS_RX && !empty) ? head : 8'h00;
    else if (hit(bus_addr, OFS_STAT))   bus_rdata[NFLAG-1:0] = flags;
    else if (hit(bus_addr, OFS_OCC))    bus_rdata[CNT_W-1:0] = count;
    else if (hit(bus_addr, OFS_PEND))   bus_rdata[NFLAG-1:0] = pend;
    else if (hit(bus_addr, OFS_MASK))   bus_rdata[NFLAG-1:0] = mask;
  end
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             empty,
  input logic             en,
  input logic             pop_ok,
  input logic             fifo_clr,
  input logic             ovf,
  input logic             ovf_clr,
  input logic             drop,
  input logic [4:0]       mask,
  input logic             irq,
  input logic             link_out_valid
);
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pop_ok && !fifo_clr) |=> count == $past(count));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 5'd0) |-> !irq);

  // R3
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_out_valid |-> !empty);
endmodule

bind trace_fifo_client tfc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .full(full), .empty(empty),
  .en(en_q), .pop_ok(pop_ok), .fifo_clr(fifo_clr), .ovf(ovf_q),
  .ovf_clr(ovf_clr), .drop(drop), .mask(mask), .irq(irq),
  .link_out_valid(link_out_valid)
);

// File: tb/trace_fifo_client_bench.sv
`timescale 1ns/1ps
module trace_fifo_client_bench;
  logic clk, rst_n;
  logic sel_tx, sel_rx, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, rdata_tx, rdata_rx;
  logic lin_valid;
  logic [7:0] lin_data;
  logic out_valid_tx, out_ready, out_valid_rx;
  logic [7:0] out_data_tx, out_data_rx;
  logic irq_tx, irq_rx;
  int checks, errors;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  trace_fifo_client #(.IS_RX(1'b0)) u_trace_fifo_client (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_tx), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_tx),
    .link_in_valid(1'b0), .link_in_data(8'h00),
    .link_out_valid(out_valid_tx), .link_out_ready(out_ready),
    .link_out_data(out_data_tx), .irq(irq_tx));

  trace_fifo_client #(.IS_RX(1'b1)) u_trace_fifo_client_rx (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_rx), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_rx),
    .link_in_valid(lin_valid), .link_in_data(lin_data),
    .link_out_valid(out_valid_rx), .link_out_ready(1'b0),
    .link_out_data(out_data_rx), .irq(irq_rx));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input bit rx, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_tx = !rx; sel_rx = rx; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    sel_tx = 1'b0; sel_rx = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input bit rx, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_tx = !rx; sel_rx = rx; bus_wr = 1'b0; bus_addr = a;
    #1 d = rx ? rdata_rx : rdata_tx;
    @(negedge clk);
    sel_tx = 1'b0; sel_rx = 1'b0;
  endtask

  task automatic lpush(input logic [7:0] b);
    @(negedge clk);
    lin_valid = 1'b1; lin_data = b;
    @(negedge clk);
    lin_valid = 1'b0;
  endtask

  // {write, requirement tag, offset, data or expected}
  localparam logic [48:0] VEC [16] = '{
    {1'b1, 4'd2,  12'h000, 32'h1},   // R2 enable
    {1'b1, 4'd2,  12'h008, 32'h2},   // R2 threshold 2
    {1'b0, 4'd5,  12'h104, 32'h0},   // R5 occupancy 0
    {1'b0, 4'd8,  12'h100, 32'h05},  // R8 empty + request
    {1'b1, 4'd3,  12'h020, 32'h41},  // R3 push
    {1'b1, 4'd3,  12'h020, 32'h42},
    {1'b1, 4'd3,  12'h020, 32'h43},
    {1'b0, 4'd5,  12'h104, 32'h3},   // R5 occupancy 3
    {1'b0, 4'd8,  12'h100, 32'h00},  // R8 3 > 2, no request
    {1'b1, 4'd11, 12'h110, 32'h04},  // R11 mask request
    {1'b1, 4'd11, 12'h114, 32'h1F},  // R11 clear all
    {1'b0, 4'd11, 12'h108, 32'h0},
    {1'b1, 4'd11, 12'h10C, 32'h10},  // R11 force timeout bit
    {1'b0, 4'd11, 12'h108, 32'h10},
    {1'b0, 4'd2,  12'h110, 32'h04},  // R2 readback
    {1'b0, 4'd2,  12'h008, 32'h2}
  };

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] got [$];
    checks = 0; errors = 0; done = 1'b0;
    sel_tx = 0; sel_rx = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    lin_valid = 0; lin_data = '0; out_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    br(0, 12'h100, v); check("R1", v & 32'h1B, 32'h01);
    br(0, 12'h104, v); check("R1", v, 32'h0);
    br(0, 12'h000, v); check("R1", v, 32'h0);
    br(1, 12'h100, v); check("R1", v & 32'h1B, 32'h01);
    check("R1", {31'd0, irq_tx | irq_rx}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][48]) bw(0, VEC[i][43:32], VEC[i][31:0]);
      else begin
        br(0, VEC[i][43:32], v);
        check($sformatf("R%0d", VEC[i][47:44]), v, VEC[i][31:0]);
      end
    end

    // R3 drain in order
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (out_valid_tx) got.push_back(out_data_tx);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check("R3", got.size(), 3);
    for (int k = 0; k < got.size() && k < 3; k++) check("R3", got[k], 32'h41 + k);

    // R11 request pending with mask drives irq; clear cannot remove live condition
    check("R11", {31'd0, irq_tx}, 32'h1);
    bw(0, 12'h114, 32'h04);
    br(0, 12'h108, v); check("R11", v & 32'h4, 32'h4);
    bw(0, 12'h110, 32'h0);
    check("R11", {31'd0, irq_tx}, 32'h0);

    // R5 / R6 fill to full, then overflow
    for (int k = 0; k < 128; k++) bw(0, 12'h020, k);
    br(0, 12'h104, v); check("R5", v, 32'd128);
    bw(0, 12'h020, 32'hEE);
    br(0, 12'h104, v); check("R6", v, 32'd128);
    br(0, 12'h100, v); check("R6", v, 32'h0A);
    // R10 flush keeps overflow, reset clears it
    bw(0, 12'h00C, 32'h2);
    br(0, 12'h100, v); check("R10", v, 32'h0D);
    bw(0, 12'h00C, 32'h1);
    br(0, 12'h100, v); check("R10", v, 32'h05);
    // R6 clear bit 3 removes overflow
    for (int k = 0; k < 129; k++) bw(0, 12'h020, k);
    bw(0, 12'h114, 32'h08);
    br(0, 12'h100, v); check("R6", v, 32'h02);
    bw(0, 12'h00C, 32'h3);
    br(0, 12'h104, v); check("R10", v, 32'h0);
    // R7 disabled push ignored
    bw(0, 12'h000, 32'h0);
    bw(0, 12'h020, 32'h55);
    br(0, 12'h104, v); check("R7", v, 32'h0);

    // receive side
    bw(1, 12'h000, 32'h1);
    bw(1, 12'h008, 32'h2);
    bw(1, 12'h004, 32'h8);
    lpush(8'h10); lpush(8'h20);
    br(1, 12'h104, v); check("R4", v, 32'h2);
    br(1, 12'h100, v); check("R8", v, 32'h04);
    br(1, 12'h020, v); check("R4", v, 32'h10);
    br(1, 12'h020, v); check("R4", v, 32'h20);
    br(1, 12'h020, v); check("R4", v, 32'h0);
    br(1, 12'h104, v); check("R4", v, 32'h0);
    // R9 idle timeout
    lpush(8'h30);
    br(1, 12'h100, v); check("R9", v, 32'h00);
    repeat (12) @(negedge clk);
    br(1, 12'h100, v); check("R9", v, 32'h10);
    br(1, 12'h020, v); check("R4", v, 32'h30);
    br(1, 12'h100, v); check("R9", v, 32'h01);
    // R7 disabled receive ignores link bytes
    bw(1, 12'h000, 32'h0);
    lpush(8'h77);
    br(1, 12'h104, v); check("R7", v, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule